// File: doc/BRIEF.md
# Parallel Programming Port Decoder

This block is the receiving side of a byte-wide parallel programming port for on-chip nonvolatile memory. A host drives an 8-bit data bus together with a two-bit mode code and a byte-select bit, and then raises a strobe. On the strobe's rising edge the byte is steered into the command register, into one half of the 16-bit address, or into one half of the 16-bit data word. A rising edge on the page-latch input stores the current data word in a page buffer at the word slot named by the low address bits. A falling edge on the write input then programs the whole page, or erases everything when the erase command is loaded. The ready output stays low while that operation is in progress.

The program array holds 16-bit words and the data array holds bytes. Both are modelled as register arrays with a fixed busy time. Programming works like real nonvolatile cells: it can only clear bits, so the stored value becomes the old contents AND the buffer. Erase sets every bit back to one. The command and the address stay loaded until the host changes them, so one command serves a whole run of reads or writes. Read commands put the addressed byte on a read-data output.

Top module: `pprog_frontend`

## Requirements
- R1: After reset, ready is 1, the command register holds 0x00 so rd_data is 0x00, the page buffer holds all ones, and every word of both arrays reads as all ones.
- R2: On a strobe rising edge, mode 2'b10 loads data_in into the command register, mode 2'b00 loads an address byte, mode 2'b01 loads a data byte, and mode 2'b11 changes nothing.
- R3: For address and data loads, bsel=0 writes the low byte (bits 7:0) and bsel=1 writes the high byte (bits 15:8). The full address is {high byte, low byte}.
- R4: The command and the address keep their values across any number of reads until they are reloaded.
- R5: A latch rising edge stores {data high, data low} into page-buffer slot address[log2(PAGE_WORDS)-1:0].
- R6: A write falling edge with command 0x10 ANDs every buffer slot w into program word {address[AW-1:log2(PAGE_WORDS)], w}. The upper bits of the address low byte therefore select the page. The buffer then returns to all ones.
- R7: A write falling edge with command 0x11 ANDs the low byte of every buffer slot into the data array using the same page addressing. The buffer then returns to all ones.
- R8: A write falling edge with command 0x80 sets every program word to 0xFFFF. It sets every data byte to 0xFF unless keep_data is 1 at that edge, in which case the data array is kept.
- R9: A write edge that starts an operation drives ready low for exactly BUSY_CYCLES clock cycles. A write edge under any command other than 0x10, 0x11 or 0x80 leaves ready high.
- R10: While ready is low, strobe, latch and write edges are ignored.
- R11: Loading command 0x00 refills the page buffer with all ones, discarding latched words.
- R12: rd_data shows program word byte (bsel selects high/low) under command 0x02, the data array byte under 0x03, and 0x00 under any other command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | Byte load strobe, acts on rising edge |
| mode_i | input | 2 | Load target code |
| bsel_i | input | 1 | Byte select, 0 low, 1 high |
| data_i | input | 8 | Data bus |
| latch_i | input | 1 | Page-buffer latch, acts on rising edge |
| wr_n_i | input | 1 | Program/erase start, acts on falling edge |
| keep_data_i | input | 1 | Keep the data array during erase |
| ready_o | output | 1 | 1 when idle, 0 while busy |
| rd_data_o | output | 8 | Read byte |

## Verification
The bench checks each array's page addressing, using a word whose page is chosen by the address high byte. A decoder that dropped those bits would read back the wrong page. It checks that programming ANDs into the array and leaves untouched slots alone, so a design that overwrote would show the new value or write 0xFF over the other slots. It shows that a no-operation command discards latched words, so a design that skipped the clear would program stale data. It sends a data load and a latch during a busy period and then a new write edge, so a design that accepted edges while busy would corrupt the stored word or lose the write command. It also checks that the erase keeps or clears the data array according to keep_data, and that ready is low for exactly BUSY_CYCLES cycles.

// File: rtl/pprog_pkg.sv
package pprog_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'b00,
        SEL_DATA = 2'b01,
        SEL_CMD  = 2'b10,
        SEL_IDLE = 2'b11
    } sel_e;

    localparam logic [7:0] OP_NOP      = 8'h00;
    localparam logic [7:0] OP_RD_FLASH = 8'h02;
    localparam logic [7:0] OP_RD_EEP   = 8'h03;
    localparam logic [7:0] OP_RD_FUSE  = 8'h04;
    localparam logic [7:0] OP_RD_SIG   = 8'h08;
    localparam logic [7:0] OP_WR_FLASH = 8'h10;
    localparam logic [7:0] OP_WR_EEP   = 8'h11;
    localparam logic [7:0] OP_WR_LOCK  = 8'h20;
    localparam logic [7:0] OP_WR_FUSE  = 8'h40;
    localparam logic [7:0] OP_ERASE    = 8'h80;

endpackage

// File: rtl/pprog_edge.sv
module pprog_edge #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic pulse_o
);

    logic hist_d, hist_q;

    always_comb begin
        hist_d = sig_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= !RISING;
        else        hist_q <= hist_d;
    end

    generate
        if (RISING) begin : g_rise
            assign pulse_o = sig_i & ~hist_q;
        end else begin : g_fall
            assign pulse_o = ~sig_i & hist_q;
        end
    endgenerate

endmodule

// File: rtl/pprog_busy.sv
module pprog_busy #(
    parameter int BUSY_CYCLES = 8,
    parameter int CW          = $clog2(BUSY_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          ready_o,
    output logic [CW-1:0] cnt_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)            cnt_d = CW'(BUSY_CYCLES);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready_o = (cnt_q == '0);
    assign cnt_o   = cnt_q;

endmodule

// File: rtl/pprog_frontend.sv
module pprog_frontend #(
    parameter int PAGE_WORDS  = 8,
    parameter int NUM_PAGES   = 64,
    parameter int BUSY_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe_i,
    input  logic [1:0] mode_i,
    input  logic       bsel_i,
    input  logic [7:0] data_i,
    input  logic       latch_i,
    input  logic       wr_n_i,
    input  logic       keep_data_i,
    output logic       ready_o,
    output logic [7:0] rd_data_o
);
    import pprog_pkg::*;

    localparam int WORDS = PAGE_WORDS * NUM_PAGES;
    localparam int AW    = $clog2(WORDS);
    localparam int WB    = $clog2(PAGE_WORDS);
    localparam int PB    = AW - WB;
    localparam int CW    = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        logic [7:0]                   cmd;
        logic [15:0]                  addr;
        logic [15:0]                  word;
        logic [PAGE_WORDS-1:0][15:0]  pbuf;
        logic [WORDS-1:0][15:0]       flash;
        logic [WORDS-1:0][7:0]        eep;
    } state_t;

    state_t st_d, st_q;

    logic          strb_pulse, lat_pulse, wr_pulse;
    logic          start;
    logic [CW-1:0] busy_cnt;
    logic [PB-1:0] page_idx;
    logic [WB-1:0] word_idx;
    logic [AW-1:0] rd_idx;

    function automatic logic [AW-1:0] slot(input logic [PB-1:0] pg, input int w);
        logic [31:0] wv;
        wv = 32'(w);
        return {pg, wv[WB-1:0]};
    endfunction

    pprog_edge #(.RISING(1'b1)) u_strb_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(strobe_i), .pulse_o(strb_pulse)
    );
    pprog_edge #(.RISING(1'b1)) u_lat_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(latch_i), .pulse_o(lat_pulse)
    );
    pprog_edge #(.RISING(1'b0)) u_wr_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(wr_n_i), .pulse_o(wr_pulse)
    );

    pprog_busy #(.BUSY_CYCLES(BUSY_CYCLES), .CW(CW)) u_busy (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ready_o(ready_o), .cnt_o(busy_cnt)
    );

    assign page_idx = st_q.addr[AW-1:WB];
    assign word_idx = st_q.addr[WB-1:0];
    assign rd_idx   = st_q.addr[AW-1:0];

    // Next-state computation
    always_comb begin
        st_d  = st_q;
        start = 1'b0;

        // byte steering, frozen while busy
        if (strb_pulse && ready_o) begin
            case (sel_e'(mode_i))
                SEL_ADDR: begin
                    if (bsel_i) st_d.addr[15:8] = data_i;
                    else        st_d.addr[7:0]  = data_i;
                end
                SEL_DATA: begin
                    if (bsel_i) st_d.word[15:8] = data_i;
                    else        st_d.word[7:0]  = data_i;
                end
                SEL_CMD: begin
                    st_d.cmd = data_i;
                    if (data_i == OP_NOP) st_d.pbuf = '1;
                end
                default: ;
            endcase
        end

        if (lat_pulse && ready_o) begin
            st_d.pbuf[word_idx] = st_q.word;
        end

        if (wr_pulse && ready_o) begin
            case (st_q.cmd)
                OP_WR_FLASH: begin
                    for (int w = 0; w < PAGE_WORDS; w++) begin
                        st_d.flash[slot(page_idx, w)] =
                            st_q.flash[slot(page_idx, w)] & st_q.pbuf[w];
                    end
                    st_d.pbuf = '1;
                    start     = 1'b1;
                end
                OP_WR_EEP: begin
                    for (int w = 0; w < PAGE_WORDS; w++) begin
                        st_d.eep[slot(page_idx, w)] =
                            st_q.eep[slot(page_idx, w)] & st_q.pbuf[w][7:0];
                    end
                    st_d.pbuf = '1;
                    start     = 1'b1;
                end
                OP_ERASE: begin
                    st_d.flash = '1;
                    if (!keep_data_i) st_d.eep = '1;
                    st_d.pbuf  = '1;
                    start      = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cmd   <= OP_NOP;
            st_q.addr  <= '0;
            st_q.word  <= '0;
            st_q.pbuf  <= '1;
            st_q.flash <= '1;
            st_q.eep   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // Read path
    always_comb begin
        case (st_q.cmd)
            OP_RD_FLASH: rd_data_o = bsel_i ? st_q.flash[rd_idx][15:8]
                                            : st_q.flash[rd_idx][7:0];
            OP_RD_EEP:   rd_data_o = st_q.eep[rd_idx];
            default:     rd_data_o = 8'h00;
        endcase
    end

    // Plain views for the bound checker
    logic [7:0]  cmd_view;
    logic [15:0] addr_view;
    logic        pbuf_ones;
    logic        unused_addr_bits;

    assign cmd_view         = st_q.cmd;
    assign addr_view        = st_q.addr;
    assign pbuf_ones        = &st_q.pbuf;
    assign unused_addr_bits = ^st_q.addr;

endmodule

// File: rtl/pprog_frontend_chk.sv
module pprog_frontend_chk #(
    parameter int BUSY_CYCLES = 8,
    parameter int CW          = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode_i,
    input logic [7:0]    data_i,
    input logic          strb_pulse,
    input logic          wr_pulse,
    input logic          ready_o,
    input logic [7:0]    cmd_view,
    input logic [15:0]   addr_view,
    input logic          pbuf_ones,
    input logic [CW-1:0] busy_cnt
);

    assert_idle_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_pulse && mode_i == 2'b11) |=> ($stable(cmd_view) && $stable(addr_view)));

    assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && ready_o && cmd_view == 8'h10) |=> !ready_o);

    assert_ready_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_o) |-> $past(wr_pulse));

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= CW'(BUSY_CYCLES));

    assert_busy_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |=> ($stable(cmd_view) && $stable(addr_view)));

    assert_nop_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_pulse && ready_o && mode_i == 2'b10 && data_i == 8'h00) |=> pbuf_ones);

endmodule

bind pprog_frontend pprog_frontend_chk #(
    .BUSY_CYCLES(BUSY_CYCLES),
    .CW(CW)
) chk_i (
    .clk(clk),
    .rst_n(rst_n),
    .mode_i(mode_i),
    .data_i(data_i),
    .strb_pulse(strb_pulse),
    .wr_pulse(wr_pulse),
    .ready_o(ready_o),
    .cmd_view(cmd_view),
    .addr_view(addr_view),
    .pbuf_ones(pbuf_ones),
    .busy_cnt(busy_cnt)
);

// File: tb/pprog_frontend_tb_top.sv
module pprog_frontend_tb_top;

    localparam int BUSY = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe = 1'b0;
    logic [1:0] mode = 2'b11;
    logic       bsel = 1'b0;
    logic [7:0] data = 8'h00;
    logic       latch = 1'b0;
    logic       wr_n = 1'b1;
    logic       keep = 1'b0;
    logic       ready;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pprog_frontend #(.PAGE_WORDS(8), .NUM_PAGES(64), .BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .mode_i(mode), .bsel_i(bsel),
        .data_i(data), .latch_i(latch), .wr_n_i(wr_n), .keep_data_i(keep),
        .ready_o(ready), .rd_data_o(rd_data)
    );

    // {addr hi, addr lo, bsel, expected byte} under read-program command
    localparam logic [24:0] RD_TAB [8] = '{
        {8'h00, 8'h08, 1'b0, 8'h10},
        {8'h00, 8'h08, 1'b1, 8'hA0},
        {8'h00, 8'h09, 1'b0, 8'h11},
        {8'h00, 8'h0B, 1'b1, 8'hA3},
        {8'h00, 8'h0C, 1'b0, 8'hFF},
        {8'h01, 8'h08, 1'b0, 8'h5A},
        {8'h01, 8'h08, 1'b1, 8'hC3},
        {8'h00, 8'h00, 1'b1, 8'hFF}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic [1:0] m, input logic b, input logic [7:0] d);
        @(negedge clk);
        mode = m; bsel = b; data = d; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0; mode = 2'b11;
    endtask

    task automatic pulse_latch();
        @(negedge clk); latch = 1'b1;
        @(negedge clk); latch = 1'b0;
    endtask

    task automatic pulse_wr();
        @(negedge clk); wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic read_at(input string req, input logic [7:0] hi, input logic [7:0] lo,
                           input logic b, input logic [7:0] exp);
        put(2'b00, 1'b1, hi);
        put(2'b00, 1'b0, lo);
        @(negedge clk); bsel = b;
        #2;
        chk(req, rd_data, exp);
    endtask

    task automatic load_word(input logic [7:0] hi, input logic [7:0] lo,
                             input logic [7:0] dhi, input logic [7:0] dlo);
        put(2'b00, 1'b1, hi);
        put(2'b00, 1'b0, lo);
        put(2'b01, 1'b0, dlo);
        put(2'b01, 1'b1, dhi);
        pulse_latch();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_chk++; n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ready", {7'd0, ready}, 8'h01);
        chk("R1 rd_data", rd_data, 8'h00);
        put(2'b10, 1'b0, 8'h02);
        read_at("R1 flash erased", 8'h00, 8'h00, 1'b0, 8'hFF);

        // R5 R6 program page 1 (words 8..11) through low-byte page bits
        put(2'b10, 1'b0, 8'h10);
        for (int w = 0; w < 4; w++)
            load_word(8'h00, 8'(8 + w), 8'(8'hA0 + w), 8'(8'h10 + w));
        pulse_wr();
        wait_ready(n);
        chk("R9 busy length", 8'(n), 8'(BUSY));

        // R3 page chosen by high address byte
        load_word(8'h01, 8'h08, 8'hC3, 8'h5A);
        pulse_wr();
        wait_ready(n);

        // R4 R12 one command, many reads
        put(2'b10, 1'b0, 8'h02);
        for (int i = 0; i < 8; i++) begin
            logic [24:0] e;
            e = RD_TAB[i];
            read_at("R4 R5 R3 R12 table read", e[24:17], e[16:9], e[8], e[7:0]);
        end

        // R2 idle mode changes nothing
        put(2'b11, 1'b0, 8'h09);
        @(negedge clk); bsel = 1'b0; #2;
        chk("R2 idle mode", rd_data, 8'hFF);

        // R6 programming ANDs, untouched slots kept
        put(2'b10, 1'b0, 8'h10);
        load_word(8'h00, 8'h08, 8'h0F, 8'h0F);
        pulse_wr();
        wait_ready(n);
        put(2'b10, 1'b0, 8'h02);
        read_at("R6 and lo", 8'h00, 8'h08, 1'b0, 8'h00);
        read_at("R6 and hi", 8'h00, 8'h08, 1'b1, 8'h00);
        read_at("R6 untouched", 8'h00, 8'h09, 1'b0, 8'h11);

        // R12 non-read command gives zero
        put(2'b10, 1'b0, 8'h04);
        @(negedge clk); #2;
        chk("R12 other cmd", rd_data, 8'h00);

        // R9 write under non-write command starts nothing
        put(2'b10, 1'b0, 8'h02);
        pulse_wr();
        chk("R9 no busy", {7'd0, ready}, 8'h01);

        // R7 data array page program
        put(2'b10, 1'b0, 8'h11);
        load_word(8'h00, 8'h02, 8'h00, 8'h77);
        load_word(8'h00, 8'h03, 8'h00, 8'h66);
        pulse_wr();
        wait_ready(n);
        put(2'b10, 1'b0, 8'h03);
        read_at("R7 eep 2", 8'h00, 8'h02, 1'b0, 8'h77);
        read_at("R7 eep 3", 8'h00, 8'h03, 1'b0, 8'h66);
        read_at("R7 eep 4", 8'h00, 8'h04, 1'b0, 8'hFF);

        // R11 no-operation discards latched words
        put(2'b10, 1'b0, 8'h10);
        load_word(8'h00, 8'h10, 8'h00, 8'h00);
        put(2'b10, 1'b0, 8'h00);
        put(2'b10, 1'b0, 8'h10);
        pulse_wr();
        wait_ready(n);
        put(2'b10, 1'b0, 8'h02);
        read_at("R11 buffer cleared", 8'h00, 8'h10, 1'b0, 8'hFF);

        // R10 edges ignored while busy
        put(2'b10, 1'b0, 8'h10);
        load_word(8'h00, 8'h18, 8'h12, 8'h34);
        pulse_wr();
        put(2'b01, 1'b0, 8'h00);
        pulse_latch();
        put(2'b10, 1'b0, 8'h02);
        wait_ready(n);
        pulse_wr();
        chk("R10 cmd kept during busy", {7'd0, ready}, 8'h00);
        wait_ready(n);
        put(2'b10, 1'b0, 8'h02);
        read_at("R10 data kept during busy", 8'h00, 8'h18, 1'b0, 8'h34);
        read_at("R10 high kept", 8'h00, 8'h18, 1'b1, 8'h12);

        // R8 erase with and without keep_data
        keep = 1'b1;
        put(2'b10, 1'b0, 8'h80);
        pulse_wr();
        wait_ready(n);
        chk("R8 erase busy", 8'(n), 8'(BUSY));
        put(2'b10, 1'b0, 8'h02);
        read_at("R8 flash erased", 8'h00, 8'h09, 1'b0, 8'hFF);
        read_at("R8 flash erased hi", 8'h01, 8'h08, 1'b1, 8'hFF);
        put(2'b10, 1'b0, 8'h03);
        read_at("R8 eep kept", 8'h00, 8'h02, 1'b0, 8'h77);
        keep = 1'b0;
        put(2'b10, 1'b0, 8'h80);
        pulse_wr();
        wait_ready(n);
        put(2'b10, 1'b0, 8'h03);
        read_at("R8 eep erased", 8'h00, 8'h02, 1'b0, 8'hFF);

        summary();
    end

endmodule